// File: doc/BRIEF.md
# Bitstream-to-PCM Decimator (128x)

This block turns the one-bit output of a fourth-order oversampled modulator into signed 16-bit PCM words. Every clock carries one modulator bit. The block lowers the rate by a fixed 128 in three stages. A fourth-order integrate-and-comb decimator divides by 32. A three-tap FIR then flattens the droop of that stage and halves the rate. A seven-tap halfband FIR halves it again and produces the final word. The same chain and the same ratio serve an 8 kHz and a 16 kHz audio band; only the modulator clock differs between them.

All coefficients are fixed constants, and each FIR stage has a DC gain of exactly one. For a bit density `d`, the settled output is therefore `(2d-1)` times 32768. The result is rounded to 16 bits and clamped at the signed limits. After reset, the output strobe stays quiet until the stage pipelines have filled.

Top module: `sd_decim128`

## Requirements
- R1: An input bit of 1 counts as +1 and a bit of 0 counts as -1, so a stream with equal numbers of ones and zeros settles to an output of 0.
- R2: `pcm_vld` is a single-cycle pulse, and once running, consecutive pulses are exactly 128 clocks apart.
- R3: For any pattern that repeats every 8 bits with k ones, the settled output is within one LSB of 4096*(2k-8) for 1 <= k <= 7.
- R4: A stream of all ones gives +32767, and a stream of all zeros gives -32768. The full-scale result is clamped to these limits and does not wrap.
- R5: After reset is released, no `pcm_vld` pulse appears in the first 768 clocks, and the first pulse arrives within 1200 clocks.
- R6: While `rst_n` is low, `pcm_vld` is 0 and `pcm_out` is 0.
- R7: `pcm_out` changes only in a cycle in which `pcm_vld` is high, and holds its value between pulses.
- R8: Results stay correct over long runs in which the internal integrators wrap around many times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; one input bit per rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously inside the block |
| bit_in | input | 1 | Modulator bitstream (1 = +1, 0 = -1) |
| pcm_out | output | 16 | Signed PCM word, updated together with `pcm_vld` |
| pcm_vld | output | 1 | One-clock strobe marking a new PCM word |

## Verification
Rounding and saturation act in the same cycle at full scale. The rounded all-ones result lands on exactly +32768, one step past the positive limit, so clamping must catch it in the cycle the word is formed. Constant all-ones and all-zeros streams provoke this case, and the bench expects exactly +32767 and -32768. During these runs, and during the intermediate-density patterns, the bench also checks that the update of the output word and the output strobe coincide: the strobe spacing must stay at 128 and the word must hold still between strobes.

// File: rtl/sd_decim_pkg.sv
package sd_decim_pkg;

  // Droop-correction FIR: taps {-1, 10, -1} / 8, DC gain 1.
  localparam int COMP_TAPS = 3;
  localparam int COMP_SH   = 3;

  // Halfband FIR: taps {-1, 0, 9, 16, 9, 0, -1} / 32, DC gain 1.
  localparam int HB_TAPS      = 7;
  localparam int HB_SH        = 5;
  localparam int HB_CENTER_SH = 4;  // centre tap 16 is applied as a shift

  function automatic int comp_coef(input int k);
    case (k)
      1:       return 10;
      default: return -1;
    endcase
  endfunction

  // Only the even-indexed (non-zero, off-centre) halfband taps.
  function automatic int hb_coef(input int k);
    case (k)
      2, 4:    return 9;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/sd_cic_decim.sv
module sd_cic_decim #(
  parameter int R = 32,
  parameter int N = 4,
  parameter int W = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_in,
  output logic signed [W-1:0] o_data,
  output logic                o_vld
);
  localparam int CW = $clog2(R);

  logic signed [W-1:0] integ_q [N];
  logic signed [W-1:0] integ_d [N];
  logic signed [W-1:0] dly_q   [N];
  logic signed [W-1:0] dly_d   [N];
  logic signed [W-1:0] comb    [N+1];
  logic signed [W-1:0] in_val;
  logic signed [W-1:0] o_data_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                strobe;

  assign in_val = bit_in ? {{(W-1){1'b0}}, 1'b1} : {W{1'b1}};
  assign strobe = (cnt_q == CW'(R - 1));

  always_comb begin
    integ_d[0] = integ_q[0] + in_val;
    for (int k = 1; k < N; k++) integ_d[k] = integ_q[k] + integ_q[k-1];
    comb[0] = integ_q[N-1];
    for (int k = 0; k < N; k++) comb[k+1] = comb[k] - dly_q[k];
    for (int k = 0; k < N; k++) dly_d[k] = strobe ? comb[k] : dly_q[k];
    o_data_d = strobe ? comb[N] : o_data;
    cnt_d    = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
      cnt_q  <= '0;
      o_data <= '0;
      o_vld  <= 1'b0;
    end else begin
      for (int k = 0; k < N; k++) begin
        integ_q[k] <= integ_d[k];
        dly_q[k]   <= dly_d[k];
      end
      cnt_q  <= cnt_d;
      o_data <= o_data_d;
      o_vld  <= strobe;
    end
  end

  // R2: decimated strobe never lasts two cycles
  p_cic_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |=> !o_vld);

endmodule

// File: rtl/sd_comp_fir.sv
module sd_comp_fir #(
  parameter int IW = 22,
  parameter int OW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [IW-1:0] i_data,
  input  logic                 i_vld,
  output logic signed [OW-1:0] o_data,
  output logic                 o_vld
);
  import sd_decim_pkg::*;
  localparam int TAPS = COMP_TAPS;
  localparam int AW   = IW + 5;

  logic signed [IW-1:0] tap_q [TAPS-1];
  logic signed [IW-1:0] tap_d [TAPS-1];
  logic signed [AW-1:0] acc;
  logic signed [OW-1:0] o_data_d;
  logic                 phase_q, phase_d, o_vld_d;

  always_comb begin
    acc = AW'(i_data) * AW'(comp_coef(0));
    for (int k = 1; k < TAPS; k++) acc = acc + AW'(tap_q[k-1]) * AW'(comp_coef(k));
    for (int k = 0; k < TAPS-1; k++) tap_d[k] = tap_q[k];
    phase_d  = phase_q;
    o_data_d = o_data;
    o_vld_d  = 1'b0;
    if (i_vld) begin
      tap_d[0] = i_data;
      for (int k = 1; k < TAPS-1; k++) tap_d[k] = tap_q[k-1];
      phase_d = ~phase_q;
      if (phase_q) begin
        o_data_d = OW'(acc >>> COMP_SH);
        o_vld_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS-1; k++) tap_q[k] <= '0;
      phase_q <= 1'b0;
      o_data  <= '0;
      o_vld   <= 1'b0;
    end else begin
      for (int k = 0; k < TAPS-1; k++) tap_q[k] <= tap_d[k];
      phase_q <= phase_d;
      o_data  <= o_data_d;
      o_vld   <= o_vld_d;
    end
  end

  // R2: half-rate strobe is a single-cycle pulse
  p_comp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |=> !o_vld);

endmodule

// File: rtl/sd_hb_out.sv
module sd_hb_out #(
  parameter int IW   = 24,
  parameter int OW   = 16,
  parameter int SHT  = 10,
  parameter int FILL = 6,
  parameter int GAP  = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [IW-1:0] i_data,
  input  logic                 i_vld,
  output logic signed [OW-1:0] o_data,
  output logic                 o_vld
);
  import sd_decim_pkg::*;
  localparam int TAPS = HB_TAPS;
  localparam int C    = (TAPS - 1) / 2;
  localparam int AW   = IW + 8;
  localparam int FW   = $clog2(FILL + 1);
  localparam int GW   = $clog2(GAP) + 1;
  localparam logic signed [AW-1:0] MAXV = AW'((2 ** (OW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = AW'(-(2 ** (OW - 1)));

  logic signed [IW-1:0] tap_q [TAPS-1];
  logic signed [IW-1:0] tap_d [TAPS-1];
  logic signed [AW-1:0] acc, rnd, q;
  logic signed [OW-1:0] sat, o_data_d;
  logic                 phase_q, phase_d, o_vld_d;
  logic [FW-1:0]        fill_q, fill_d;

  always_comb begin
    // odd off-centre taps are zero and are skipped
    acc = (AW'(tap_q[C-1]) <<< HB_CENTER_SH) + AW'(i_data) * AW'(hb_coef(0));
    for (int k = 2; k < TAPS; k += 2) acc = acc + AW'(tap_q[k-1]) * AW'(hb_coef(k));
    rnd = acc + (AW'(1) <<< (SHT - 1));
    q   = rnd >>> SHT;
    if (q > MAXV)      sat = OW'(MAXV);
    else if (q < MINV) sat = OW'(MINV);
    else               sat = OW'(q);
  end

  always_comb begin
    for (int k = 0; k < TAPS-1; k++) tap_d[k] = tap_q[k];
    phase_d  = phase_q;
    fill_d   = fill_q;
    o_data_d = o_data;
    o_vld_d  = 1'b0;
    if (i_vld) begin
      tap_d[0] = i_data;
      for (int k = 1; k < TAPS-1; k++) tap_d[k] = tap_q[k-1];
      phase_d = ~phase_q;
      if (phase_q) begin
        if (fill_q == FW'(FILL)) begin
          o_data_d = sat;
          o_vld_d  = 1'b1;
        end else begin
          fill_d = fill_q + FW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS-1; k++) tap_q[k] <= '0;
      phase_q <= 1'b0;
      fill_q  <= '0;
      o_data  <= '0;
      o_vld   <= 1'b0;
    end else begin
      for (int k = 0; k < TAPS-1; k++) tap_q[k] <= tap_d[k];
      phase_q <= phase_d;
      fill_q  <= fill_d;
      o_data  <= o_data_d;
      o_vld   <= o_vld_d;
    end
  end

  // checker state: cycles since the previous output strobe
  logic [GW-1:0] gap_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_q | o_vld;
      if (o_vld)                    gap_q <= '0;
      else if (gap_q != {GW{1'b1}}) gap_q <= gap_q + GW'(1);
    end
  end

  // R2: strobes are exactly GAP clocks apart
  p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && seen_q) |-> (gap_q == GW'(GAP - 1)));

  // R7: word holds between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !o_vld |-> $stable(o_data));

endmodule

// File: rtl/sd_decim128.sv
module sd_decim128 #(
  parameter int CIC_R = 32,
  parameter int CIC_N = 4,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_in,
  output logic signed [OUT_W-1:0] pcm_out,
  output logic                    pcm_vld
);
  import sd_decim_pkg::*;
  localparam int GAIN_BITS = CIC_N * $clog2(CIC_R);
  localparam int CIC_W     = GAIN_BITS + 2;
  localparam int COMP_W    = CIC_W + 2;
  localparam int DEC_TOTAL = CIC_R * 4;
  localparam int OUT_SHIFT = HB_SH + GAIN_BITS - (OUT_W - 1);
  localparam int FILL      = (HB_TAPS + 1) / 2 + 2;
  localparam int MIN_FIRST = DEC_TOTAL * FILL;
  localparam int SW        = $clog2(MIN_FIRST) + 2;

  logic [1:0]                rst_sync_q;
  logic                      rst_int_n;
  logic signed [CIC_W-1:0]   cic_data;
  logic                      cic_vld;
  logic signed [COMP_W-1:0]  comp_data;
  logic                      comp_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sd_cic_decim #(.R(CIC_R), .N(CIC_N), .W(CIC_W)) u_cic (
    .clk(clk), .rst_n(rst_int_n), .bit_in(bit_in),
    .o_data(cic_data), .o_vld(cic_vld));

  sd_comp_fir #(.IW(CIC_W), .OW(COMP_W)) u_comp (
    .clk(clk), .rst_n(rst_int_n), .i_data(cic_data), .i_vld(cic_vld),
    .o_data(comp_data), .o_vld(comp_vld));

  sd_hb_out #(.IW(COMP_W), .OW(OUT_W), .SHT(OUT_SHIFT), .FILL(FILL),
              .GAP(DEC_TOTAL)) u_hb (
    .clk(clk), .rst_n(rst_int_n), .i_data(comp_data), .i_vld(comp_vld),
    .o_data(pcm_out), .o_vld(pcm_vld));

  // checker state: clocks since internal reset release
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)               since_q <= '0;
    else if (since_q != {SW{1'b1}}) since_q <= since_q + SW'(1);
  end

  // R5: no output before the pipelines have filled
  p_first_vld_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    pcm_vld |-> (since_q >= SW'(MIN_FIRST)));

endmodule

// File: tb/sim_sd_decim128.sv
`timescale 1ns/1ps
module sim_sd_decim128;
  logic clk = 1'b0;
  logic rst_n;
  logic bit_in;
  logic signed [15:0] pcm_out;
  logic pcm_vld;

  always #10 clk = ~clk;

  sd_decim128 u0 (.clk(clk), .rst_n(rst_n), .bit_in(bit_in),
                  .pcm_out(pcm_out), .pcm_vld(pcm_vld));

  // {8-bit repeating pattern, expected settled output}
  localparam logic [23:0] VEC [8] = '{
    {8'hFF,        16'sd32767},
    {8'h00,       -16'sd32768},
    {8'b10101010,  16'sd0},
    {8'b11101110,  16'sd16384},
    {8'b00010001, -16'sd16384},
    {8'b11111110,  16'sd24576},
    {8'b00100101, -16'sd8192},
    {8'b01101011,  16'sd8192}
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] pat = 8'h00;
  int pos = 0, cyc = 0, last_cyc = 0, nvld = 0, gap_bad = 0, hold_bad = 0;
  bit seen = 1'b0;
  logic signed [15:0] last_out = '0, prev_out = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (pcm_vld) begin
      if (seen && (cyc - last_cyc) != 128) gap_bad++;
      seen = 1'b1; last_cyc = cyc; last_out = pcm_out; nvld++;
    end else if (pcm_out != prev_out) hold_bad++;
    prev_out = pcm_out;
    bit_in = pat[pos];
    pos = (pos + 1) % 8;
    cyc++;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pcm_vld == 1'b0, {tag, " R6 vld in reset"}, int'(pcm_vld), 0);
    check(pcm_out == 16'sd0, {tag, " R6 out in reset"}, int'(pcm_out), 0);
    rst_n = 1'b1;
    seen = 1'b0; prev_out = '0; cyc = 0;
  endtask

  task automatic fill_check(input string tag);
    int first = -1;
    for (int i = 0; i < 1500 && first < 0; i++) begin
      step();
      if (pcm_vld) first = cyc;
    end
    check(first >= 768, {tag, " R5 first strobe too early"}, first, 768);
    check(first > 0 && first <= 1200, {tag, " R5 first strobe late"}, first, 1200);
  endtask

  initial begin
    rst_n = 1'b0; bit_in = 1'b0;
    do_reset("init");
    pat = 8'hFF;
    fill_check("init");

    for (int v = 0; v < 8; v++) begin
      int exp;
      pat = VEC[v][23:16];
      exp = int'($signed(VEC[v][15:0]));
      repeat (8) step();           // let the pattern take hold
      gap_bad = 0; hold_bad = 0; nvld = 0;
      repeat (36 * 128) step();
      if (exp == 32767 || exp == -32768)
        check(int'(last_out) == exp, "R4 R1 full-scale clamp", int'(last_out), exp);
      else
        check(int'(last_out) - exp <= 1 && exp - int'(last_out) <= 1,
              "R3 R1 settled DC level", int'(last_out), exp);
      check(gap_bad == 0, "R2 strobe spacing", gap_bad, 0);
      check(nvld == 36, "R2 strobes per 128 bits", nvld, 36);
      check(hold_bad == 0, "R7 hold between strobes", hold_bad, 0);
    end

    // R8: long run, integrators wrap many times
    pat = 8'b11101110;
    gap_bad = 0;
    repeat (64 * 128) step();
    check(int'(last_out) - 16384 <= 1 && 16384 - int'(last_out) <= 1,
          "R8 long-run level", int'(last_out), 16384);
    check(gap_bad == 0, "R8 R2 long-run spacing", gap_bad, 0);

    // mid-stream reset
    do_reset("mid");
    pat = 8'h00;
    fill_check("mid");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule